// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the processor-facing half of a two-channel serial controller. It exposes four byte-wide ports on a small bus window: each channel has a control port and a data port. Control registers are reached indirectly. A control write loads a per-channel register pointer, and the next control access writes or reads the register it selects, after which the pointer falls back to zero. Each channel keeps sixteen 8-bit write registers. Its readable state is a fixed status register, plus one pending register that is shared by both channels and lives in channel 1.

Received characters arrive on a per-channel available/character input, which is consumed by data-port reads. Transmit bytes leave as a one-cycle strobe with data for each channel. A single level interrupt output is recomputed in the cycle after every bus access and on a free-running periodic tick. It is gated by per-channel enables in write register 1 and by a master enable in channel 1's write register 9.

Top module: `dual_serial_regif`

## Requirements
- R1: After reset the interrupt output is 0, no transmit strobe is active, both pointers are 0, the shared pending register reads 0, and every write register is 0.
- R2: The port index is the bus address shifted right by STRIDE_LOG2. Index bit 1 selects the channel and index bit 0 selects control (0) or data (1). The address bits below the stride are ignored.
- R3: A control write while the pointer is 0 loads the pointer. A byte below 16 loads its low 4 bits; a byte of 16 or more loads only its low 3 bits.
- R4: A control write while the pointer is nonzero stores the byte in the selected write register and returns the pointer to 0.
- R5: A control read returns the read register selected by the pointer and returns the pointer to 0. Read registers other than 0, and other than register 3 of channel 1, read as 0.
- R6: Read register 0 of a channel reads 0x2C OR the receive-ready bit (bit 0). Transmit-ready (bit 2), carrier-detect (bit 3) and clear-to-send (bit 5) are always set.
- R7: A pointer-loading control write whose bits 7:3 are 00111 (bytes 0x38 to 0x3F), on either channel, clears the shared pending register. That register is read register 3 of channel 1.
- R8: A data write pulses that channel's tx_stb for one cycle with the byte on tx_byte, unless the byte is 0. A data write always sets the channel's transmit-pending bit: bit 1 for channel 0, bit 4 for channel 1.
- R9: A data read returns rx_char if rx_avail is set, and 0 otherwise. It pulses rx_pop only when a character is available, and it clears the channel's receive-ready bit.
- R10: Each evaluation first clears the receive-pending bits (bit 2 for channel 0, bit 5 for channel 1). If no transmit interrupt is active, it then sets each bit from rx_avail, together with that channel's receive-ready bit. A transmit interrupt is active when a channel has its transmit-pending bit set and bit 1 of its write register 1 set; in that case the receive check is skipped.
- R11: The evaluated interrupt is 1 in two cases: a transmit interrupt is active, or a receive-pending bit is set while bits 4:3 of that channel's write register 1 are nonzero. The result is forced to 0 unless bit 3 of channel 1's write register 9 is set.
- R12: The interrupt output changes only in the cycle after a bus access, or after a tick that comes every TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_sel is high |
| rx_avail | input | 2 | Received character available, per channel |
| rx_char | input | 16 | Received character, channel c at bits 8c+7:8c |
| rx_pop | output | 2 | Character consumed, per channel |
| irq | output | 1 | Level interrupt request |
| tx_stb | output | 2 | Transmit byte strobe, per channel |
| tx_byte | output | 16 | Transmit byte, channel c at bits 8c+7:8c |

## Verification
The hardest state to reach is the skipped receive check. It needs a transmit-pending bit and that channel's transmit enable both set, and a character must then arrive and be seen by a periodic tick, with no bus access in between. Random stimulus rarely reaches this order of events. A directed sequence therefore builds it: it enables the transmit interrupt, issues a data write, raises rx_avail, and waits past a tick. It then reads the shared register to confirm the receive bits stayed clear. It issues the clear command next and confirms they reappear. Random pointer and data traffic, with random sub-stride address bits, covers the rest against a bench model.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int NCH  = 2;
  localparam int NREG = 16;
  localparam int PW   = $clog2(NREG);
  // status register 0 bits
  localparam int S0_RXRDY = 0;
  localparam int S0_TXRDY = 2;
  localparam int S0_DCD   = 3;
  localparam int S0_CTS   = 5;
  // shared pending register bits
  localparam int PB_TX = 1;
  localparam int PB_RX = 2;
  localparam int PA_TX = 4;
  localparam int PA_RX = 5;
  // write register fields
  localparam int W1_TIE   = 1;
  localparam int W9_MIE   = 3;
  localparam logic [4:0] CLR_CODE = 5'b00111;

  function automatic logic [PW-1:0] ptr_load(input logic [7:0] v);
    return (v < 8'd16) ? v[PW-1:0] : {1'b0, v[2:0]};
  endfunction

  function automatic logic [7:0] status0(input logic rdy);
    logic [7:0] s;
    s = '0;
    s[S0_TXRDY] = 1'b1;
    s[S0_DCD]   = 1'b1;
    s[S0_CTS]   = 1'b1;
    s[S0_RXRDY] = rdy;
    return s;
  endfunction

  function automatic logic irq_decide(input logic tx_act, input logic rxp0,
                                      input logic rxp1, input logic [7:0] w1_0,
                                      input logic [7:0] w1_1, input logic [7:0] w9);
    logic a;
    a = tx_act | (rxp0 & (|w1_0[4:3])) | (rxp1 & (|w1_1[4:3]));
    return a & w9[W9_MIE];
  endfunction
endpackage

// File: rtl/dsr_ticker.sv
module dsr_ticker #(
  parameter int TICK_DIV = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/dsr_chan.sv
module dsr_chan
  import dsr_pkg::*;
#(
  parameter bit OWNS_SHARED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       is_data,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       rx_avail,
  input  logic [7:0] rx_char,
  input  logic       set_rdy,
  input  logic [7:0] pend,
  output logic [7:0] rdata,
  output logic [7:0] wr1,
  output logic [7:0] wr9,
  output logic       clr_cmd,
  output logic       tx_fire,
  output logic       rx_pop,
  output logic       tx_stb,
  output logic [7:0] tx_byte
);
  logic [PW-1:0] ptr_q;
  logic [7:0]    wr_q [NREG];
  logic          rdy_q;

  // named access events
  logic ctl_wr, ctl_rd, dat_wr, dat_rd;
  assign ctl_wr  = acc & ~is_data & we;
  assign ctl_rd  = acc & ~is_data & ~we;
  assign dat_wr  = acc & is_data & we;
  assign dat_rd  = acc & is_data & ~we;
  assign clr_cmd = ctl_wr & (ptr_q == '0) & (wdata[7:3] == CLR_CODE);
  assign tx_fire = dat_wr;
  assign rx_pop  = dat_rd & rx_avail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rdy_q   <= 1'b0;
      tx_stb  <= 1'b0;
      tx_byte <= '0;
      for (int i = 0; i < NREG; i++) wr_q[i] <= '0;
    end else begin
      if (ctl_wr) begin
        if (ptr_q == '0) ptr_q <= ptr_load(wdata);
        else begin
          wr_q[ptr_q] <= wdata;
          ptr_q <= '0;
        end
      end else if (ctl_rd) begin
        ptr_q <= '0;
      end
      if (dat_rd) rdy_q <= 1'b0;
      else if (set_rdy) rdy_q <= 1'b1;
      tx_stb <= dat_wr & (wdata != 8'h00);
      if (dat_wr) tx_byte <= wdata;
    end
  end

  assign wr1 = wr_q[1];
  assign wr9 = wr_q[9];

  always_comb begin
    if (is_data) rdata = rx_avail ? rx_char : 8'h00;
    else begin
      case (ptr_q)
        PW'(0):  rdata = status0(rdy_q);
        PW'(3):  rdata = OWNS_SHARED ? pend : 8'h00;
        default: rdata = 8'h00;
      endcase
    end
  end

  assert_ptr_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ptr_q != '0) |=> (ptr_q == '0));
  assert_ptr_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> (ptr_q == '0));
  assert_status_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && ptr_q == '0) |-> (rdata[5:2] == 4'b1011));
  assert_rdy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd |=> !rdy_q);
  assert_zero_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && wdata == 8'h00) |=> !tx_stb);
endmodule

// File: rtl/dsr_irq_ctl.sv
module dsr_irq_ctl
  import dsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic [1:0] tx_fire,
  input  logic [1:0] clr_cmd,
  input  logic [1:0] rx_avail,
  input  logic [7:0] wr1_0,
  input  logic [7:0] wr1_1,
  input  logic [7:0] wr9_1,
  output logic [7:0] pend_q,
  output logic [1:0] set_rdy,
  output logic       irq_q
);
  logic       tx_act;
  logic [7:0] pend_upd, pend_nxt;
  logic       irq_new;

  always_comb begin
    tx_act = (pend_q[PB_TX] & wr1_0[W1_TIE]) | (pend_q[PA_TX] & wr1_1[W1_TIE]);
    pend_upd = pend_q;
    pend_upd[PB_RX] = 1'b0;
    pend_upd[PA_RX] = 1'b0;
    set_rdy = 2'b00;
    if (!tx_act) begin
      pend_upd[PB_RX] = rx_avail[0];
      pend_upd[PA_RX] = rx_avail[1];
      if (upd) set_rdy = rx_avail;
    end
    irq_new = irq_decide(tx_act, pend_upd[PB_RX], pend_upd[PA_RX], wr1_0, wr1_1, wr9_1);
    pend_nxt = upd ? pend_upd : pend_q;
    pend_nxt[PB_TX] = pend_nxt[PB_TX] | tx_fire[0];
    pend_nxt[PA_TX] = pend_nxt[PA_TX] | tx_fire[1];
    if (|clr_cmd) pend_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      if (upd) irq_q <= irq_new;
    end
  end

  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_cmd) |=> (pend_q == 8'h00));
  assert_rx_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && tx_act && !(|clr_cmd)) |=> (!pend_q[PB_RX] && !pend_q[PA_RX]));
  assert_master_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr9_1[W9_MIE]) |=> !irq_q);
  assert_irq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(irq_q));
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import dsr_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STRIDE_LOG2 = 0,
  parameter int TICK_DIV    = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        rx_avail,
  input  logic [15:0]       rx_char,
  output logic [1:0]        rx_pop,
  output logic              irq,
  output logic [1:0]        tx_stb,
  output logic [15:0]       tx_byte
);
  logic [1:0] port_idx;
  logic       sel_ch;
  logic       acc_q, tick, upd;
  logic [7:0] ch_rd  [NCH];
  logic [7:0] ch_wr1 [NCH];
  logic [7:0] ch_wr9 [NCH];
  logic [1:0] clr_cmd, tx_fire, set_rdy;
  logic [7:0] pend;

  assign port_idx = bus_addr[STRIDE_LOG2 +: 2];
  assign sel_ch   = port_idx[1];

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= 1'b0;
    else acc_q <= bus_sel;
  end

  dsr_ticker #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));
  assign upd = acc_q | tick;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dsr_chan #(.OWNS_SHARED(g == 1)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .acc(bus_sel && (sel_ch == 1'(g))),
      .is_data(port_idx[0]), .we(bus_we), .wdata(bus_wdata),
      .rx_avail(rx_avail[g]), .rx_char(rx_char[8*g +: 8]),
      .set_rdy(set_rdy[g]), .pend(pend),
      .rdata(ch_rd[g]), .wr1(ch_wr1[g]), .wr9(ch_wr9[g]),
      .clr_cmd(clr_cmd[g]), .tx_fire(tx_fire[g]), .rx_pop(rx_pop[g]),
      .tx_stb(tx_stb[g]), .tx_byte(tx_byte[8*g +: 8])
    );
  end

  dsr_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .upd(upd), .tx_fire(tx_fire), .clr_cmd(clr_cmd),
    .rx_avail(rx_avail), .wr1_0(ch_wr1[0]), .wr1_1(ch_wr1[1]), .wr9_1(ch_wr9[1]),
    .pend_q(pend), .set_rdy(set_rdy), .irq_q(irq)
  );

  assign bus_rdata = bus_sel ? ch_rd[sel_ch] : 8'h00;

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_stb));
  assert_pop_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_pop) |-> (bus_sel && !bus_we && port_idx[0]));
endmodule

// File: tb/dual_serial_regif_test.sv
module dual_serial_regif_test;
  localparam int CLK_PERIOD = 10;
  localparam int STRIDE = 1;
  localparam int AW = 4;
  localparam int TICK = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] rx_avail = '0, rx_pop, tx_stb;
  logic [15:0] rx_char = '0, tx_byte;
  logic irq;

  int checks = 0, errors = 0;

  dual_serial_regif #(.ADDR_W(AW), .STRIDE_LOG2(STRIDE), .TICK_DIV(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_avail(rx_avail), .rx_char(rx_char),
    .rx_pop(rx_pop), .irq(irq), .tx_stb(tx_stb), .tx_byte(tx_byte));

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model
  logic [3:0] m_ptr [2];
  logic [7:0] m_wr1 [2];
  logic [7:0] m_wr9a, m_pend;
  logic       m_rdy [2];
  logic       m_irq;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctl_read(input int ch);
    if (m_ptr[ch] == 4'd0) return 8'h2C | {7'd0, m_rdy[ch]};
    if (m_ptr[ch] == 4'd3 && ch == 1) return m_pend;
    return 8'h00;
  endfunction

  function automatic void m_eval();
    logic tx, a;
    tx = (m_pend[1] & m_wr1[0][1]) | (m_pend[4] & m_wr1[1][1]);
    m_pend[2] = 1'b0;
    m_pend[5] = 1'b0;
    if (!tx) begin
      if (rx_avail[0]) begin m_pend[2] = 1'b1; m_rdy[0] = 1'b1; end
      if (rx_avail[1]) begin m_pend[5] = 1'b1; m_rdy[1] = 1'b1; end
    end
    a = tx | (m_pend[2] & (|m_wr1[0][4:3])) | (m_pend[5] & (|m_wr1[1][4:3]));
    m_irq = a & m_wr9a[3];
  endfunction

  task automatic do_acc(input int ch, input bit isdat, input bit wr, input logic [7:0] wd,
                        output logic [7:0] got);
    logic [7:0] exp_rd;
    bit exp_pop, exp_stb;
    exp_rd = 8'h00; exp_pop = 0; exp_stb = 0;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = wr; bus_wdata = wd;
    // R2: sub-stride address bit is random and must be ignored
    bus_addr = AW'(({ch[0], isdat} << STRIDE) | $urandom_range(0, 1));
    if (!isdat && !wr) begin
      exp_rd = exp_ctl_read(ch);
      m_ptr[ch] = 4'd0;
    end else if (!isdat && wr) begin
      if (m_ptr[ch] == 4'd0) begin
        m_ptr[ch] = (wd < 8'd16) ? wd[3:0] : {1'b0, wd[2:0]};
        if (wd[7:3] == 5'b00111) m_pend = 8'h00;
      end else begin
        if (m_ptr[ch] == 4'd1) m_wr1[ch] = wd;
        if (m_ptr[ch] == 4'd9 && ch == 1) m_wr9a = wd;
        m_ptr[ch] = 4'd0;
      end
    end else if (isdat && !wr) begin
      exp_rd = rx_avail[ch] ? rx_char[8*ch +: 8] : 8'h00;
      exp_pop = rx_avail[ch];
      m_rdy[ch] = 1'b0;
    end else begin
      exp_stb = (wd != 8'h00);
      m_pend = m_pend | (ch == 1 ? 8'h10 : 8'h02);
    end
    #1;
    got = bus_rdata;
    if (!wr) check(bus_rdata == exp_rd, isdat ? "R9 data read" : "R5 R2 control read",
                   bus_rdata, exp_rd);
    if (isdat && !wr) check(rx_pop[ch] == exp_pop, "R9 rx_pop", rx_pop, exp_pop);
    @(negedge clk);
    bus_sel = 1'b0;
    if (isdat && wr) begin
      check(tx_stb == (exp_stb ? 2'(1 << ch) : 2'b00), "R8 tx strobe", tx_stb,
            exp_stb ? (1 << ch) : 0);
      if (exp_stb) check(tx_byte[8*ch +: 8] == wd, "R8 tx byte", tx_byte[8*ch +: 8], wd);
    end
    m_eval();
    repeat (2) @(negedge clk);
    check(irq == m_irq, "R11 irq level", irq, m_irq);
  endtask

  task automatic set_rx(input logic [1:0] av, input logic [15:0] chars);
    @(negedge clk);
    rx_avail = av; rx_char = chars;
    repeat (TICK + 4) @(negedge clk);
    m_eval();
    check(irq == m_irq, "R12 R11 irq after tick", irq, m_irq);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 2; c++) begin m_ptr[c] = 0; m_wr1[c] = 0; m_rdy[c] = 0; end
    m_wr9a = 0; m_pend = 0; m_irq = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq reset", irq, 0);
    check(tx_stb == 2'b00, "R1 strobe reset", tx_stb, 0);
    do_acc(0, 0, 0, 8'h00, rd);
    check(rd == 8'h2C, "R1 R6 status reset ch0", rd, 8'h2C);
    do_acc(1, 0, 1, 8'h03, rd);
    do_acc(1, 0, 0, 8'h00, rd);
    check(rd == 8'h00, "R1 shared pend reset", rd, 0);

    // R3: 0x19 loads pointer 1 (low 3 bits), then R4 writes wr1 = transmit enable
    do_acc(0, 0, 1, 8'h19, rd);
    do_acc(0, 0, 1, 8'h02, rd);
    do_acc(1, 0, 1, 8'h09, rd);
    do_acc(1, 0, 1, 8'h08, rd);
    // R12: irq updates one cycle after the access edge
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = AW'(1 << STRIDE); bus_wdata = 8'h41;
    @(negedge clk);
    bus_sel = 0;
    check(irq == 1'b0, "R12 irq not yet", irq, 0);
    check(tx_stb == 2'b01 && tx_byte[7:0] == 8'h41, "R8 directed strobe", tx_stb, 1);
    @(negedge clk);
    check(irq == 1'b1, "R12 R3 R4 irq one cycle later", irq, 1);
    m_pend = m_pend | 8'h02; m_eval();

    // R10: transmit interrupt active -> receive check skipped
    do_acc(1, 0, 1, 8'h01, rd);
    do_acc(1, 0, 1, 8'h10, rd);
    set_rx(2'b10, 16'h5A00);
    do_acc(1, 0, 1, 8'h03, rd);
    do_acc(1, 0, 0, 8'h00, rd);
    check(rd == 8'h02, "R10 rx skipped under tx irq", rd, 8'h02);
    do_acc(1, 0, 0, 8'h00, rd);
    check(rd[0] == 1'b0, "R10 rx-ready not set", rd[0], 0);
    // R7: clear command then rx reappears
    do_acc(0, 0, 1, 8'h3B, rd);
    do_acc(1, 0, 1, 8'h03, rd);
    do_acc(1, 0, 0, 8'h00, rd);
    check(rd == 8'h20, "R7 R10 pend after clear", rd, 8'h20);
    check(irq == 1'b1, "R11 rx irq", irq, 1);
    do_acc(1, 1, 0, 8'h00, rd);
    check(rd == 8'h5A, "R9 char read", rd, 8'h5A);
    do_acc(0, 1, 1, 8'h00, rd);
    do_acc(0, 1, 0, 8'h00, rd);
    check(rd == 8'h00, "R9 empty read", rd, 0);

    // random traffic against the model
    for (int n = 0; n < 400; n++) begin
      int ch, op;
      logic [7:0] wd;
      ch = $urandom_range(0, 1);
      op = $urandom_range(0, 9);
      if (op < 4) begin
        if (m_ptr[ch] == 0) begin
          case ($urandom_range(0, 5))
            0: wd = 8'h01;
            1: wd = 8'h09;
            2: wd = 8'h03;
            3: wd = 8'h38 | 8'($urandom_range(0, 7));
            default: wd = 8'($urandom_range(0, 255));
          endcase
        end else wd = 8'($urandom_range(0, 255));
        do_acc(ch, 0, 1, wd, rd);
      end else if (op < 6) do_acc(ch, 0, 0, 8'h00, rd);
      else if (op < 7) do_acc(ch, 1, 0, 8'h00, rd);
      else if (op < 9) do_acc(ch, 1, 1, ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(1, 255)), rd);
      else set_rx(2'($urandom_range(0, 3)), 16'($urandom_range(0, 65535)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule